// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a CPU and a flash array model. It lets software erase a flash page, write a page from the page buffer, load one word into that buffer, or program the lock bits. Software first writes a command byte into the control register. It then raises a store-program strobe while presenting a word address and a data word. The strobe only counts if it arrives within a short window after the register write. If no strobe comes in time, the armed command clears itself.

An accepted command sends a one-cycle request to the flash array, together with the page, word index and data. Erase and write are long operations. While one runs, the enable bit stays set until the array raises its done input. If the target page lies in the read-while-write region, a sticky busy flag marks that region as unreadable and the CPU keeps running. If the page lies outside that region, the CPU halt output is held until the operation completes. Software clears the busy flag with a dedicated re-enable write.

An interrupt request is raised for as long as interrupts are enabled and the enable bit is clear, so it can replace polling. While the EEPROM reports a write in progress, register writes and strobes are both ignored.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, `ctrl_q` is 0x00, and `rww_busy`, `cpu_halt`, `irq` and all four request outputs are low.
- R2: The control register fields are: bit 0 enable, bit 1 erase, bit 2 write, bit 3 lock set, bit 4 region re-enable, bit 6 busy flag (read-only), bit 7 interrupt enable. A write with bit 0 set and bit 4 clear arms bits 4:0 as a command. The valid commands have bits 4:0 equal to 0x01 (load), 0x03 (erase), 0x05 (write) or 0x09 (lock). Bit 7 is stored for all of them.
- R3: A strobe 1 to 4 clock edges after the register-write edge executes the command. With no strobe by edge 4, bits 4:0 clear at that edge. A strobe on edge 5 or later does nothing.
- R4: An accepted load pulses `fl_load_req` for one cycle, starting in the cycle after the strobe. It presents `fl_word` = z_addr[4:0] and `fl_data` = wr_data, and clears bits 4:0.
- R5: An accepted erase pulses `fl_erase_req` with `fl_page` = z_addr[11:5]. All other address bits are ignored.
- R6: A write is executed only when z_addr[4:0] and z_addr[15:12] are zero. Otherwise no request is made and bits 4:0 clear.
- R7: An erase or write to a page below 96 sets `rww_busy` and leaves `cpu_halt` low. A page of 96 or more holds `cpu_halt` high until `fl_done`.
- R8: During an erase or write, the enable bit stays set and register writes are ignored. The cycle after `fl_done`, bits 4:0 are zero.
- R9: `rww_busy` (also read as bit 6) stays set until a register write with bits 4 and 0 both set. That write does not arm a command.
- R10: `irq` is high exactly when bit 7 is set and bit 0 is clear.
- R11: While `ee_busy` is high, register writes and strobes have no effect.
- R12: An accepted lock set pulses `fl_lock_req` with `fl_data` = wr_data, whose low byte carries the lock bits, and clears bits 4:0.
- R13: A strobe while nothing is armed, or with an invalid command combination, makes no request and clears bits 4:0. At most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register readback |
| spm_stb | input | 1 | Store-program strobe |
| z_addr | input | 16 | Word address: page in [11:5], word in [4:0] |
| wr_data | input | 16 | Data word for buffer load or lock bits |
| ee_busy | input | 1 | EEPROM write in progress |
| fl_done | input | 1 | Flash array reports erase/write finished |
| fl_load_req | output | 1 | Buffer load request pulse |
| fl_erase_req | output | 1 | Page erase request pulse |
| fl_write_req | output | 1 | Page write request pulse |
| fl_lock_req | output | 1 | Lock-bit programming request pulse |
| fl_page | output | 7 | Target page |
| fl_word | output | 5 | Buffer word index |
| fl_data | output | 16 | Data to the array |
| rww_busy | output | 1 | Read-while-write region blocked |
| cpu_halt | output | 1 | Stall the CPU |
| irq | output | 1 | Operation-complete interrupt request |

## Verification
The hardest case to reach from the ports is the exact edge of the arming window. A strobe must land on the fourth edge after the write, or one edge later, while no other write restarts the count. The stimulus steps through strobe delays of 1 to 6 edges after each register write, using both directed and random delays. This exercises the accept and reject boundary for loads and erases. A second hard case is a register write issued during a long operation. The bench issues that write between the erase request and the done pulse, then checks that the register is unchanged.

// File: rtl/flash_selfprog_pkg.sv
package flash_selfprog_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_ERASE,
    OP_WRITE,
    OP_LOCK,
    OP_BAD
  } op_e;

  // Classify the armed command bits [4:0]
  function automatic op_e decode_cmd(input logic [4:0] c);
    op_e r;
    if (!c[0]) begin
      r = OP_NONE;
    end else if (c[4]) begin
      r = OP_BAD;
    end else begin
      case (c[3:1])
        3'b000:  r = OP_LOAD;
        3'b001:  r = OP_ERASE;
        3'b010:  r = OP_WRITE;
        3'b100:  r = OP_LOCK;
        default: r = OP_BAD;
      endcase
    end
    return r;
  endfunction

  function automatic logic is_long_op(input op_e o);
    return (o == OP_ERASE) || (o == OP_WRITE);
  endfunction

endpackage

// File: rtl/flash_selfprog_window.sv
module flash_selfprog_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic armed,
  output logic expire
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic at_limit(input logic [CW-1:0] c);
    return c == CW'(WINDOW);
  endfunction

  assign expire = armed & ~start & ~cancel & at_limit(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      armed <= 1'b1;
      cnt_q <= CW'(1);
    end else if (cancel) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (at_limit(cnt_q)) armed <= 1'b0;
      else                 cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/flash_selfprog_addr.sv
module flash_selfprog_addr #(
  parameter int Z_W       = 16,
  parameter int PAGE_W    = 7,
  parameter int WORD_W    = 5,
  parameter int RWW_PAGES = 96
) (
  input  logic [Z_W-1:0]    z,
  output logic [PAGE_W-1:0] page,
  output logic [WORD_W-1:0] word,
  output logic              in_rww,
  output logic              wr_addr_ok
);
  localparam int HI_W = Z_W - PAGE_W - WORD_W;

  logic hi_zero;

  function automatic logic page_in_rww(input logic [PAGE_W-1:0] pg);
    return {{(32-PAGE_W){1'b0}}, pg} < 32'(RWW_PAGES);
  endfunction

  assign word = z[WORD_W-1:0];
  assign page = z[WORD_W+PAGE_W-1:WORD_W];

  generate
    if (HI_W > 0) begin : g_hi
      assign hi_zero = (z[Z_W-1:WORD_W+PAGE_W] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign in_rww     = page_in_rww(page);
  assign wr_addr_ok = hi_zero & (word == '0);
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import flash_selfprog_pkg::*;
#(
  parameter int Z_W       = 16,
  parameter int PAGE_W    = 7,
  parameter int WORD_W    = 5,
  parameter int DATA_W    = 16,
  parameter int RWW_PAGES = 96,
  parameter int WINDOW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_q,
  input  logic              spm_stb,
  input  logic [Z_W-1:0]    z_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ee_busy,
  input  logic              fl_done,
  output logic              fl_load_req,
  output logic              fl_erase_req,
  output logic              fl_write_req,
  output logic              fl_lock_req,
  output logic [PAGE_W-1:0] fl_page,
  output logic [WORD_W-1:0] fl_word,
  output logic [DATA_W-1:0] fl_data,
  output logic              rww_busy,
  output logic              cpu_halt,
  output logic              irq
);
  logic [4:0] cmd_q;
  logic       irq_en_q, op_busy_q, halt_q, rww_q;

  // named internal events
  logic wr_ok, wr_reen, wr_arm, armed, win_expire, stb_take, op_done, go_long;
  logic [PAGE_W-1:0] a_page;
  logic [WORD_W-1:0] a_word;
  logic a_in_rww, a_wr_ok;
  op_e  op;
  logic unused_bits;

  assign unused_bits = ^reg_wdata[6:5];

  flash_selfprog_addr #(
    .Z_W(Z_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W), .RWW_PAGES(RWW_PAGES)
  ) u_addr (
    .z(z_addr), .page(a_page), .word(a_word),
    .in_rww(a_in_rww), .wr_addr_ok(a_wr_ok)
  );

  assign wr_ok   = reg_wr & ~ee_busy & ~op_busy_q;
  assign wr_reen = wr_ok & reg_wdata[4] & reg_wdata[0];
  assign wr_arm  = wr_ok & reg_wdata[0] & ~reg_wdata[4];

  flash_selfprog_window #(.WINDOW(WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .start(wr_arm), .cancel(stb_take | (wr_ok & ~wr_arm)),
    .armed(armed), .expire(win_expire)
  );

  assign op       = decode_cmd(cmd_q);
  assign stb_take = spm_stb & armed & ~ee_busy & ~wr_ok;
  assign op_done  = op_busy_q & fl_done;
  assign go_long  = stb_take &
                    ((op == OP_ERASE) || ((op == OP_WRITE) && a_wr_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q        <= '0;
      irq_en_q     <= 1'b0;
      op_busy_q    <= 1'b0;
      halt_q       <= 1'b0;
      rww_q        <= 1'b0;
      fl_load_req  <= 1'b0;
      fl_erase_req <= 1'b0;
      fl_write_req <= 1'b0;
      fl_lock_req  <= 1'b0;
      fl_page      <= '0;
      fl_word      <= '0;
      fl_data      <= '0;
    end else begin
      fl_load_req  <= 1'b0;
      fl_erase_req <= 1'b0;
      fl_write_req <= 1'b0;
      fl_lock_req  <= 1'b0;
      if (wr_ok) begin
        irq_en_q <= reg_wdata[7];
        cmd_q    <= wr_arm ? reg_wdata[4:0] : 5'd0;
        if (wr_reen) rww_q <= 1'b0;
      end else if (op_done) begin
        cmd_q     <= '0;
        op_busy_q <= 1'b0;
        halt_q    <= 1'b0;
      end else if (stb_take) begin
        case (op)
          OP_LOAD: begin
            fl_load_req <= 1'b1;
            fl_word     <= a_word;
            fl_data     <= wr_data;
            cmd_q       <= '0;
          end
          OP_LOCK: begin
            fl_lock_req <= 1'b1;
            fl_data     <= wr_data;
            cmd_q       <= '0;
          end
          OP_ERASE, OP_WRITE: begin
            if (go_long) begin
              fl_erase_req <= (op == OP_ERASE);
              fl_write_req <= (op == OP_WRITE);
              fl_page      <= a_page;
              op_busy_q    <= 1'b1;
              if (a_in_rww) rww_q  <= 1'b1;
              else          halt_q <= 1'b1;
            end else begin
              cmd_q <= '0;
            end
          end
          default: cmd_q <= '0;
        endcase
      end else if (win_expire) begin
        cmd_q <= '0;
      end
    end
  end

  assign ctrl_q   = {irq_en_q, rww_q, 1'b0, cmd_q};
  assign rww_busy = rww_q;
  assign cpu_halt = halt_q;
  assign irq      = irq_en_q & ~cmd_q[0];

  // op_busy_q only ever holds a long operation
  logic unused_long;
  assign unused_long = is_long_op(op) & 1'b0;
endmodule

// File: rtl/flash_selfprog_chk.sv
module flash_selfprog_chk #(
  parameter int PAGE_W    = 7,
  parameter int RWW_PAGES = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              ee_busy,
  input logic [7:0]        ctrl_q,
  input logic              fl_load_req,
  input logic              fl_erase_req,
  input logic              fl_write_req,
  input logic              fl_lock_req,
  input logic [PAGE_W-1:0] fl_page,
  input logic              rww_busy,
  input logic              cpu_halt,
  input logic              irq,
  input logic              win_expire
);
  a_r3_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (ctrl_q[4:0] == 5'd0));

  a_r13_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_load_req, fl_erase_req, fl_write_req, fl_lock_req}));

  a_r11_ee_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy |=> !(fl_load_req | fl_erase_req | fl_write_req | fl_lock_req));

  a_r8_halt_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> ctrl_q[0]);

  a_r9_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rww_busy && !reg_wr) |=> rww_busy);

  a_r10_irq_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[0]) && ctrl_q[7]) |-> irq);

  a_r4_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fl_load_req |=> !fl_load_req);

  a_r7_rww_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_erase_req || fl_write_req) &&
     ({{(32-PAGE_W){1'b0}}, fl_page} < 32'(RWW_PAGES))) |-> (!cpu_halt && rww_busy));
endmodule

bind flash_selfprog_ctrl flash_selfprog_chk #(
  .PAGE_W(PAGE_W), .RWW_PAGES(RWW_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ee_busy(ee_busy),
  .ctrl_q(ctrl_q), .fl_load_req(fl_load_req), .fl_erase_req(fl_erase_req),
  .fl_write_req(fl_write_req), .fl_lock_req(fl_lock_req), .fl_page(fl_page),
  .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq), .win_expire(win_expire)
);

// File: tb/sim_flash_selfprog_ctrl.sv
module sim_flash_selfprog_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, spm_stb = 1'b0, ee_busy = 1'b0, fl_done = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] z_addr = '0, wr_data = '0;
  logic [7:0]  ctrl_q;
  logic fl_load_req, fl_erase_req, fl_write_req, fl_lock_req;
  logic [6:0]  fl_page;
  logic [4:0]  fl_word;
  logic [15:0] fl_data;
  logic rww_busy, cpu_halt, irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flash_selfprog_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .spm_stb(spm_stb), .z_addr(z_addr), .wr_data(wr_data),
    .ee_busy(ee_busy), .fl_done(fl_done), .fl_load_req(fl_load_req),
    .fl_erase_req(fl_erase_req), .fl_write_req(fl_write_req),
    .fl_lock_req(fl_lock_req), .fl_page(fl_page), .fl_word(fl_word),
    .fl_data(fl_data), .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq)
  );

  function automatic logic [15:0] mkz(input logic [3:0] hi, input logic [6:0] pg,
                                      input logic [4:0] wd);
    return {hi, pg, wd};
  endfunction
  function automatic logic exp_rww(input logic [6:0] pg);
    return int'(pg) < 96;
  endfunction
  function automatic logic exp_accept(input int d);
    return (d >= 1) && (d <= 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // strobe lands on the d-th edge after the last write edge
  task automatic stb(input int d, input logic [15:0] z, input logic [15:0] dat);
    for (int i = 1; i < d; i++) @(negedge clk);
    spm_stb = 1'b1; z_addr = z; wr_data = dat;
    @(negedge clk);
    spm_stb = 1'b0;
  endtask

  task automatic finish_op(input int lat);
    for (int i = 0; i < lat; i++) @(negedge clk);
    fl_done = 1'b1;
    @(negedge clk);
    fl_done = 1'b0;
  endtask

  function automatic logic [3:0] reqs();
    return {fl_lock_req, fl_write_req, fl_erase_req, fl_load_req};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 outs", {rww_busy, cpu_halt, irq, reqs()}, 0);

    // R2/R3/R4 load accepted on edge 4
    wr(8'h01);
    chk("R2 armed", ctrl_q, 8'h01);
    stb(4, mkz(4'h0, 7'd3, 5'd17), 16'hBEEF);
    chk("R3 R4 load req", reqs(), 4'b0001);
    chk("R4 word", fl_word, 5'd17);
    chk("R4 data", fl_data, 16'hBEEF);
    chk("R4 cleared", ctrl_q, 8'h00);
    @(negedge clk);
    chk("R4 one pulse", reqs(), 4'b0000);

    // R3 strobe on edge 5 rejected
    wr(8'h01);
    stb(5, 16'h0001, 16'h1234);
    chk("R3 late strobe", reqs(), 4'b0000);
    chk("R3 expired", ctrl_q, 8'h00);

    // R13 strobe with nothing armed
    stb(2, 16'h0001, 16'h1);
    chk("R13 unarmed", reqs(), 4'b0000);

    // R5/R7/R8/R10 erase in RWW region, irq enabled
    wr(8'h83);
    chk("R10 irq low while enabled", irq, 1'b0);
    stb(2, mkz(4'hF, 7'd10, 5'd3), 16'h0);
    chk("R5 erase req", reqs(), 4'b0010);
    chk("R5 page", fl_page, 7'd10);
    chk("R7 rww busy", {rww_busy, cpu_halt}, 2'b10);
    chk("R8 en held", ctrl_q, 8'hC3);
    wr(8'h01);
    chk("R8 write ignored", ctrl_q, 8'hC3);
    finish_op(3);
    chk("R8 done clears", ctrl_q, 8'hC0);
    chk("R10 irq", irq, 1'b1);
    chk("R9 sticky", rww_busy, 1'b1);
    wr(8'h11);
    chk("R9 reenable", {ctrl_q, rww_busy, irq}, 10'h000);

    // R7 erase outside RWW region halts
    wr(8'h03);
    stb(1, mkz(4'h0, 7'd100, 5'd0), 16'h0);
    chk("R7 halt", {rww_busy, cpu_halt}, 2'b01);
    repeat (3) @(negedge clk);
    chk("R7 halt held", cpu_halt, 1'b1);
    finish_op(1);
    chk("R7 halt released", {cpu_halt, ctrl_q}, 9'h000);

    // R6 write with nonzero word or upper bits dropped
    wr(8'h05);
    stb(3, mkz(4'h0, 7'd5, 5'd1), 16'h0);
    chk("R6 word nonzero", {reqs(), ctrl_q}, 12'h000);
    wr(8'h05);
    stb(3, mkz(4'h1, 7'd5, 5'd0), 16'h0);
    chk("R6 upper nonzero", {reqs(), ctrl_q}, 12'h000);
    wr(8'h05);
    stb(3, mkz(4'h0, 7'd5, 5'd0), 16'h0);
    chk("R6 write req", reqs(), 4'b0100);
    chk("R6 page", fl_page, 7'd5);
    finish_op(2);
    wr(8'h11);

    // R12 lock
    wr(8'h09);
    stb(1, 16'h0001, 16'h00C3);
    chk("R12 lock req", reqs(), 4'b1000);
    chk("R12 data", fl_data[7:0], 8'hC3);
    chk("R12 cleared", ctrl_q, 8'h00);

    // R13 invalid combination
    wr(8'h07);
    stb(2, 16'h0, 16'h0);
    chk("R13 bad combo", {reqs(), ctrl_q}, 12'h000);

    // R11 EEPROM busy
    ee_busy = 1'b1;
    wr(8'h81);
    chk("R11 write ignored", ctrl_q, 8'h00);
    ee_busy = 1'b0;
    wr(8'h01);
    ee_busy = 1'b1;
    stb(2, 16'h0, 16'h5);
    chk("R11 strobe ignored", reqs(), 4'b0000);
    ee_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 R3 expiry", ctrl_q, 8'h00);

    // random loads and erases with random strobe delay
    for (int it = 0; it < 40; it++) begin
      int d;
      logic is_er;
      logic [15:0] z, dt;
      d = int'($urandom % 6) + 1;
      is_er = $urandom % 2;
      z = 16'($urandom) & 16'h0FFF;
      dt = 16'($urandom);
      wr(is_er ? 8'h03 : 8'h01);
      stb(d, z, dt);
      if (!exp_accept(d)) begin
        chk("R3 rand reject", {reqs(), ctrl_q}, 12'h000);
      end else if (!is_er) begin
        chk("R4 rand load", {reqs(), fl_word, fl_data}, {4'b0001, z[4:0], dt});
      end else begin
        chk("R5 rand erase", {reqs(), fl_page}, {4'b0010, z[11:5]});
        chk("R7 rand region", {rww_busy, cpu_halt},
            {exp_rww(z[11:5]), !exp_rww(z[11:5])});
        finish_op(int'($urandom % 4));
        wr(8'h11);
        chk("R9 rand clear", rww_busy, 1'b0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule